// File: doc/BRIEF.md
# Virtual Interrupt Pending-Bit Delivery Engine

This block takes a request to set or clear the pending state of one virtual message-signalled interrupt in a virtual pending bitmap held in memory. It reads the byte that holds the interrupt's bit, rewrites the byte only when the bit must change, and reports whether the bit changed. When the target virtual processor is resident on this redistributor, the block asks the priority scanner to do one of two things. After a set, it asks for a single-ID check. After a clear, it asks for a full rescan, but only when the cleared ID was the cached best. When the target is not resident, the block raises a physical doorbell interrupt instead.

A move request first clears the bit in a source table. If the bit was set there, the block may request a rescan of the source. It then delivers the interrupt with level set to the destination table, using the same rules as an ordinary delivery. The read-modify-write is atomic: no new request is accepted until the current one has finished. The priority scan itself lives outside this block.

Top module: `vlpi_deliver`

## Requirements
- R1: The pending bit for interrupt ID `n` in a table whose byte address is `B` is bit `n % 8` of the byte at address `B + n / 8` (bit 0 = least significant bit of the byte).
- R2: If the stored bit already equals the requested level, no memory write is issued and `done_changed` is 0.
- R3: If the stored bit differs from the requested level, exactly one write is issued to the same byte. It changes only that bit, and `done_changed` is 1.
- R4: For a resident target, a request whose ID is at or above 2^(idbits+1) is dropped. No memory access occurs, `done_changed` is 0, and no check, rescan or doorbell is raised. An ID of exactly 2^(idbits+1)-1 is processed normally.
- R5: For a resident target whose bit changes to set, one `chk_valid` pulse carries the request's ID. No rescan is raised.
- R6: For a resident target whose bit changes to clear, one `rescan_valid` pulse with `rescan_src`=0 is raised only when the ID equals the supplied cached best ID. Otherwise no rescan is raised. No check is raised in either case.
- R7: A `doorbell_valid` pulse carrying `req_doorbell_id` is raised exactly when the target is not resident, the level is set, the doorbell ID is not 1023, and `lpi_enable` is 1. This holds whether or not the bit changed.
- R8: For a non-resident target, the pending bit is still updated, no ID range drop applies, and neither a check nor a rescan is raised.
- R9: A move clears the ID's bit in the source table. If that bit was already clear, the request ends with `done_changed`=0 and without touching the destination.
- R10: When a move clears a set source bit, a `rescan_valid` pulse with `rescan_src`=1 is raised if the source is resident and the ID equals the source's cached best. The destination delivery with level set then follows, under R4 to R8.
- R11: `req_ready` is 0 from acceptance until the cycle after `done_valid`. Every write occurs two cycles after a read of the same address.
- R12: After reset `req_ready` is 1, and no memory access, check, rescan, doorbell or done pulse is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_move | input | 1 | 1 = move from source table to destination, 0 = plain delivery |
| req_id | input | ID_W | Virtual interrupt ID |
| req_level | input | 1 | Requested pending state (ignored for a move, which always sets at the destination) |
| req_tbl_addr | input | ADDR_W | Destination pending-table byte address |
| req_resident | input | 1 | Destination virtual processor is resident |
| req_idbits | input | IDB_W | Destination ID width minus one |
| req_best_id | input | ID_W | Destination cached best ID |
| req_doorbell_id | input | ID_W | Physical doorbell interrupt ID |
| req_src_tbl_addr | input | ADDR_W | Source pending-table byte address (move) |
| req_src_resident | input | 1 | Source virtual processor is resident (move) |
| req_src_best_id | input | ID_W | Source cached best ID (move) |
| lpi_enable | input | 1 | Physical interrupts enabled, sampled with the request |
| mem_rd_en | output | 1 | Byte read strobe; data returns on the next cycle |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| chk_valid | output | 1 | Single-ID priority check request (no-shift priority mode) |
| chk_id | output | ID_W | ID to check |
| rescan_valid | output | 1 | Full rescan request |
| rescan_src | output | 1 | 1 = rescan the source table, 0 = the destination |
| doorbell_valid | output | 1 | Raise the physical doorbell |
| doorbell_id | output | ID_W | Doorbell interrupt ID |
| done_valid | output | 1 | Request finished |
| done_changed | output | 1 | The destination bit changed |

## Verification
The bench builds the block with ID_W=14, ADDR_W=12 and IDB_W=4. With these values a 4 KiB byte memory model holds several tables side by side. idbits can also be set both well below and at the full ID width. So the range drop is exercised on both sides of the 1024 boundary, and large IDs land in byte offsets above 1 KiB. The 14-bit ID width also lets doorbell IDs sit on both sides of the spurious value 1023.

// File: rtl/vlpi_deliver_pkg.sv
package vlpi_deliver_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_START  = 3'd1,
      ST_READ   = 3'd2,
      ST_EVAL   = 3'd3,
      ST_WRITE  = 3'd4,
      ST_SRCEND = 3'd5,
      ST_FINISH = 3'd6
   } vd_state_e;

   localparam int unsigned BITS_PER_BYTE = 8;

endpackage

// File: rtl/vlpi_locate.sv
module vlpi_locate #(
   parameter int ID_W   = 16,
   parameter int ADDR_W = 32,
   parameter int IDB_W  = 5
) (
   input  logic [ID_W-1:0]   id,
   input  logic [ADDR_W-1:0] base,
   input  logic [IDB_W-1:0]  idbits,
   input  logic              range_chk,
   output logic [ADDR_W-1:0] byte_addr,
   output logic [2:0]        bit_sel,
   output logic              out_of_range
);
   localparam int SHW = IDB_W + 1;

   logic [SHW-1:0] span;

   always_comb begin
      span         = {1'b0, idbits} + SHW'(1);
      byte_addr    = base + ADDR_W'(id >> 3);
      bit_sel      = id[2:0];
      out_of_range = 1'b0;
      if (range_chk && (int'(span) < ID_W)) begin
         out_of_range = ((id >> span) != '0);
      end
   end
endmodule

// File: rtl/vlpi_bit_rmw.sv
module vlpi_bit_rmw (
   input  logic [7:0] rdata,
   input  logic [2:0] bit_sel,
   input  logic       level,
   output logic [7:0] wdata,
   output logic       changed
);
   for (genvar b = 0; b < vlpi_deliver_pkg::BITS_PER_BYTE; b++) begin : g_bit
      assign wdata[b] = (bit_sel == 3'(b)) ? level : rdata[b];
   end

   assign changed = (rdata[bit_sel] != level);
endmodule

// File: rtl/vlpi_outcome.sv
module vlpi_outcome #(
   parameter int ID_W        = 16,
   parameter int SPURIOUS_ID = 1023
) (
   input  logic            resident,
   input  logic            level,
   input  logic            changed,
   input  logic [ID_W-1:0] id,
   input  logic [ID_W-1:0] best_id,
   input  logic [ID_W-1:0] db_id,
   input  logic            lpi_en,
   output logic            want_chk,
   output logic            want_rescan,
   output logic            want_door
);
   localparam logic [ID_W-1:0] SPUR = ID_W'(SPURIOUS_ID);

   always_comb begin
      want_chk    = resident && changed && level;
      want_rescan = resident && changed && !level && (id == best_id);
      want_door   = !resident && level && (db_id != SPUR) && lpi_en;
   end
endmodule

// File: rtl/vlpi_deliver.sv
module vlpi_deliver
   import vlpi_deliver_pkg::*;
#(
   parameter int ID_W        = 16,
   parameter int ADDR_W      = 32,
   parameter int IDB_W       = 5,
   parameter int SPURIOUS_ID = 1023
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_move,
   input  logic [ID_W-1:0]   req_id,
   input  logic              req_level,
   input  logic [ADDR_W-1:0] req_tbl_addr,
   input  logic              req_resident,
   input  logic [IDB_W-1:0]  req_idbits,
   input  logic [ID_W-1:0]   req_best_id,
   input  logic [ID_W-1:0]   req_doorbell_id,
   input  logic [ADDR_W-1:0] req_src_tbl_addr,
   input  logic              req_src_resident,
   input  logic [ID_W-1:0]   req_src_best_id,
   input  logic              lpi_enable,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              chk_valid,
   output logic [ID_W-1:0]   chk_id,
   output logic              rescan_valid,
   output logic              rescan_src,
   output logic              doorbell_valid,
   output logic [ID_W-1:0]   doorbell_id,
   output logic              done_valid,
   output logic              done_changed
);
   initial begin
      if (ID_W < 10) $fatal(1, "ID_W must hold the spurious ID");
      if (ADDR_W < ID_W - 3) $fatal(1, "ADDR_W too narrow for table offsets");
      if (IDB_W < 1) $fatal(1, "IDB_W must be positive");
      if (SPURIOUS_ID >= (1 << ID_W)) $fatal(1, "SPURIOUS_ID out of range");
   end

   vd_state_e state_q;

   logic [ID_W-1:0]   id_q, best_q, db_q, src_best_q;
   logic [ADDR_W-1:0] base_q, src_base_q;
   logic [IDB_W-1:0]  idb_q;
   logic              lvl_q, res_q, lpien_q, src_res_q;
   logic              src_phase_q;
   logic [7:0]        wdata_q;
   logic              fin_chk_q, fin_rescan_q, fin_door_q, fin_chg_q;
   logic              src_rescan_q;

   logic [ADDR_W-1:0] act_base, byte_addr;
   logic              act_level, act_rangechk;
   logic [2:0]        bit_sel;
   logic              drop;
   logic [7:0]        new_byte;
   logic              bit_chg;
   logic              w_chk, w_rescan, w_door;

   assign act_base     = src_phase_q ? src_base_q : base_q;
   assign act_level    = src_phase_q ? 1'b0 : lvl_q;
   assign act_rangechk = !src_phase_q && res_q;

   vlpi_locate #(
      .ID_W(ID_W), .ADDR_W(ADDR_W), .IDB_W(IDB_W)
   ) u_locate (
      .id          (id_q),
      .base        (act_base),
      .idbits      (idb_q),
      .range_chk   (act_rangechk),
      .byte_addr   (byte_addr),
      .bit_sel     (bit_sel),
      .out_of_range(drop)
   );

   vlpi_bit_rmw u_rmw (
      .rdata  (mem_rdata),
      .bit_sel(bit_sel),
      .level  (act_level),
      .wdata  (new_byte),
      .changed(bit_chg)
   );

   vlpi_outcome #(
      .ID_W(ID_W), .SPURIOUS_ID(SPURIOUS_ID)
   ) u_outcome (
      .resident   (res_q),
      .level      (lvl_q),
      .changed    (bit_chg),
      .id         (id_q),
      .best_id    (best_q),
      .db_id      (db_q),
      .lpi_en     (lpien_q),
      .want_chk   (w_chk),
      .want_rescan(w_rescan),
      .want_door  (w_door)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         id_q         <= '0;
         best_q       <= '0;
         db_q         <= '0;
         src_best_q   <= '0;
         base_q       <= '0;
         src_base_q   <= '0;
         idb_q        <= '0;
         lvl_q        <= 1'b0;
         res_q        <= 1'b0;
         lpien_q      <= 1'b0;
         src_res_q    <= 1'b0;
         src_phase_q  <= 1'b0;
         wdata_q      <= '0;
         fin_chk_q    <= 1'b0;
         fin_rescan_q <= 1'b0;
         fin_door_q   <= 1'b0;
         fin_chg_q    <= 1'b0;
         src_rescan_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  id_q        <= req_id;
                  best_q      <= req_best_id;
                  db_q        <= req_doorbell_id;
                  src_best_q  <= req_src_best_id;
                  base_q      <= req_tbl_addr;
                  src_base_q  <= req_src_tbl_addr;
                  idb_q       <= req_idbits;
                  lvl_q       <= req_move ? 1'b1 : req_level;
                  res_q       <= req_resident;
                  lpien_q     <= lpi_enable;
                  src_res_q   <= req_src_resident;
                  src_phase_q <= req_move;
                  state_q     <= ST_START;
               end
            end
            ST_START: begin
               if (drop) begin
                  fin_chk_q    <= 1'b0;
                  fin_rescan_q <= 1'b0;
                  fin_door_q   <= 1'b0;
                  fin_chg_q    <= 1'b0;
                  state_q      <= ST_FINISH;
               end else begin
                  state_q <= ST_READ;
               end
            end
            ST_READ: state_q <= ST_EVAL;
            ST_EVAL: begin
               wdata_q <= new_byte;
               if (src_phase_q) begin
                  src_rescan_q <= src_res_q && (id_q == src_best_q);
                  fin_chk_q    <= 1'b0;
                  fin_rescan_q <= 1'b0;
                  fin_door_q   <= 1'b0;
                  fin_chg_q    <= 1'b0;
                  state_q      <= bit_chg ? ST_WRITE : ST_FINISH;
               end else begin
                  fin_chk_q    <= w_chk;
                  fin_rescan_q <= w_rescan;
                  fin_door_q   <= w_door;
                  fin_chg_q    <= bit_chg;
                  state_q      <= bit_chg ? ST_WRITE : ST_FINISH;
               end
            end
            ST_WRITE: state_q <= src_phase_q ? ST_SRCEND : ST_FINISH;
            ST_SRCEND: begin
               src_phase_q <= 1'b0;
               state_q     <= ST_START;
            end
            ST_FINISH: state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready      = (state_q == ST_IDLE);
      mem_rd_en      = (state_q == ST_READ);
      mem_wr_en      = (state_q == ST_WRITE);
      mem_addr       = byte_addr;
      mem_wdata      = wdata_q;
      chk_valid      = (state_q == ST_FINISH) && fin_chk_q;
      chk_id         = id_q;
      rescan_valid   = ((state_q == ST_FINISH) && fin_rescan_q) ||
                       ((state_q == ST_SRCEND) && src_rescan_q);
      rescan_src     = (state_q == ST_SRCEND);
      doorbell_valid = (state_q == ST_FINISH) && fin_door_q;
      doorbell_id    = db_q;
      done_valid     = (state_q == ST_FINISH);
      done_changed   = (state_q == ST_FINISH) && fin_chg_q;
   end
endmodule

// File: rtl/vlpi_deliver_chk.sv
module vlpi_deliver_chk #(
   parameter int ID_W        = 16,
   parameter int ADDR_W      = 32,
   parameter int SPURIOUS_ID = 1023
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              mem_rd_en,
   input logic              mem_wr_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              chk_valid,
   input logic              rescan_valid,
   input logic              doorbell_valid,
   input logic [ID_W-1:0]   doorbell_id,
   input logic              done_valid
);
   // R11
   write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ($past(mem_rd_en, 2) && ($past(mem_addr, 2) == mem_addr)));

   // R11
   busy_during_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en || mem_rd_en) |-> !req_ready);

   // R11
   ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> req_ready);

   // R7
   no_spurious_door_chk: assert property (@(posedge clk) disable iff (!rst_n)
      doorbell_valid |-> (doorbell_id != ID_W'(SPURIOUS_ID)));

   // R8
   door_excludes_chk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      doorbell_valid |-> !(chk_valid || rescan_valid));

   // R6
   chk_rescan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(chk_valid && rescan_valid));

   // R12
   one_mem_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd_en, mem_wr_en}));
endmodule

bind vlpi_deliver vlpi_deliver_chk #(
   .ID_W(ID_W), .ADDR_W(ADDR_W), .SPURIOUS_ID(SPURIOUS_ID)
) u_vlpi_deliver_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_ready     (req_ready),
   .mem_rd_en     (mem_rd_en),
   .mem_wr_en     (mem_wr_en),
   .mem_addr      (mem_addr),
   .chk_valid     (chk_valid),
   .rescan_valid  (rescan_valid),
   .doorbell_valid(doorbell_valid),
   .doorbell_id   (doorbell_id),
   .done_valid    (done_valid)
);

// File: tb/test_vlpi_deliver.sv
`timescale 1ns/1ps
module test_vlpi_deliver;
   localparam int ID_W = 14, ADDR_W = 12, IDB_W = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              req_valid = 0, req_move = 0, req_level = 0, req_resident = 0;
   logic              req_src_resident = 0, lpi_enable = 0;
   logic [ID_W-1:0]   req_id = '0, req_best_id = '0, req_doorbell_id = '0, req_src_best_id = '0;
   logic [ADDR_W-1:0] req_tbl_addr = '0, req_src_tbl_addr = '0;
   logic [IDB_W-1:0]  req_idbits = '0;
   logic              req_ready, mem_rd_en, mem_wr_en;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_wdata, mem_rdata;
   logic              chk_valid, rescan_valid, rescan_src, doorbell_valid, done_valid, done_changed;
   logic [ID_W-1:0]   chk_id, doorbell_id;

   vlpi_deliver #(.ID_W(ID_W), .ADDR_W(ADDR_W), .IDB_W(IDB_W)) i_vlpi_deliver (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_move(req_move), .req_id(req_id), .req_level(req_level),
      .req_tbl_addr(req_tbl_addr), .req_resident(req_resident), .req_idbits(req_idbits),
      .req_best_id(req_best_id), .req_doorbell_id(req_doorbell_id),
      .req_src_tbl_addr(req_src_tbl_addr), .req_src_resident(req_src_resident),
      .req_src_best_id(req_src_best_id), .lpi_enable(lpi_enable),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .chk_valid(chk_valid), .chk_id(chk_id), .rescan_valid(rescan_valid),
      .rescan_src(rescan_src), .doorbell_valid(doorbell_valid), .doorbell_id(doorbell_id),
      .done_valid(done_valid), .done_changed(done_changed));

   logic [7:0] mem [4096];
   always @(posedge clk) begin
      if (mem_wr_en) mem[mem_addr] <= mem_wdata;
      if (mem_rd_en) mem_rdata <= mem[mem_addr];
   end

   int errors = 0, checks = 0;
   int n_rd, n_wr, n_chk, n_resc_dst, n_resc_src, n_door, n_done, busy_bad;
   int last_chk_id, last_door_id, last_changed;
   int src_resc_before_chk;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_en) n_rd++;
         if (mem_wr_en) n_wr++;
         if ((mem_rd_en || mem_wr_en) && req_ready) busy_bad++;
         if (chk_valid) begin
            n_chk++; last_chk_id = int'(chk_id);
         end
         if (rescan_valid && rescan_src) begin
            n_resc_src++; if (n_chk == 0) src_resc_before_chk = 1;
         end
         if (rescan_valid && !rescan_src) n_resc_dst++;
         if (doorbell_valid) begin
            n_door++; last_door_id = int'(doorbell_id);
         end
         if (done_valid) begin
            n_done++; last_changed = int'(done_changed);
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_counts();
      n_rd = 0; n_wr = 0; n_chk = 0; n_resc_dst = 0; n_resc_src = 0;
      n_door = 0; n_done = 0; last_chk_id = -1; last_door_id = -1;
      last_changed = -1; src_resc_before_chk = 0;
   endtask

   task automatic issue(input logic mv, input int id, input logic lvl, input int base,
                        input logic res, input int idb, input int best, input int db,
                        input logic lpien, input int sbase, input logic sres, input int sbest);
      clear_counts();
      @(negedge clk);
      req_move = mv; req_id = ID_W'(id); req_level = lvl; req_tbl_addr = ADDR_W'(base);
      req_resident = res; req_idbits = IDB_W'(idb); req_best_id = ID_W'(best);
      req_doorbell_id = ID_W'(db); lpi_enable = lpien; req_src_tbl_addr = ADDR_W'(sbase);
      req_src_resident = sres; req_src_best_id = ID_W'(sbest);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 50 && n_done == 0; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R12 ready after reset", int'(req_ready), 1);
      check("R12 no outputs after reset",
            int'(mem_rd_en | mem_wr_en | chk_valid | rescan_valid | doorbell_valid | done_valid), 0);
   endtask

   task automatic t_set_resident();
      // id 8195 -> byte 0x100 + 1024 = 0x500, bit 3
      issue(0, 8195, 1, 'h100, 1, 13, 5, 2000, 1, 0, 0, 0);
      check("R1 R3 byte written", int'(mem['h500]), 'h08);
      check("R3 changed", last_changed, 1);
      check("R3 one write", n_wr, 1);
      check("R5 check pulse", n_chk, 1);
      check("R5 check id", last_chk_id, 8195);
      check("R5 no rescan", n_resc_dst, 0);
      check("R7 resident no doorbell", n_door, 0);
   endtask

   task automatic t_unchanged();
      issue(0, 8195, 1, 'h100, 1, 13, 5, 2000, 1, 0, 0, 0);
      check("R2 no write", n_wr, 0);
      check("R2 changed flag", last_changed, 0);
      check("R2 no check", n_chk, 0);
      check("R2 byte kept", int'(mem['h500]), 'h08);
   endtask

   task automatic t_clear_best();
      mem['h500] = 8'h18;
      issue(0, 8195, 0, 'h100, 1, 13, 8195, 0, 1, 0, 0, 0);
      check("R6 rescan when best cleared", n_resc_dst, 1);
      check("R6 no check on clear", n_chk, 0);
      check("R3 only target bit cleared", int'(mem['h500]), 'h10);
   endtask

   task automatic t_clear_other();
      // id 42 -> byte 0x100 + 5 = 0x105, bit 2
      mem['h105] = 8'h04;
      issue(0, 42, 0, 'h100, 1, 13, 43, 0, 1, 0, 0, 0);
      check("R6 no rescan for non-best", n_resc_dst, 0);
      check("R6 bit cleared", int'(mem['h105]), 'h00);
      check("R6 changed", last_changed, 1);
   endtask

   task automatic t_range();
      issue(0, 1024, 1, 'h300, 1, 9, 0, 0, 1, 0, 0, 0);
      check("R4 dropped no read", n_rd, 0);
      check("R4 dropped no write", n_wr, 0);
      check("R4 dropped unchanged", last_changed, 0);
      check("R4 dropped no check", n_chk, 0);
      check("R4 byte untouched", int'(mem['h380]), 0);
      // 1023 -> byte 0x300 + 127 = 0x37F, bit 7
      issue(0, 1023, 1, 'h300, 1, 9, 0, 0, 1, 0, 0, 0);
      check("R4 boundary accepted", int'(mem['h37F]), 'h80);
      check("R4 boundary check pulse", n_chk, 1);
   endtask

   task automatic t_nonresident();
      // id 2000 -> byte 0x200 + 250 = 0x2FA, bit 0; idbits 9 not applied
      issue(0, 2000, 1, 'h200, 0, 9, 2000, 8300, 1, 0, 0, 0);
      check("R8 bit set non-resident", int'(mem['h2FA]), 'h01);
      check("R8 no check", n_chk, 0);
      check("R7 doorbell raised", n_door, 1);
      check("R7 doorbell id", last_door_id, 8300);
      issue(0, 2000, 1, 'h200, 0, 9, 0, 8300, 1, 0, 0, 0);
      check("R7 doorbell even if unchanged", n_door, 1);
      issue(0, 2001, 1, 'h200, 0, 13, 0, 1023, 1, 0, 0, 0);
      check("R7 spurious doorbell suppressed", n_door, 0);
      issue(0, 2002, 1, 'h200, 0, 13, 0, 8300, 0, 0, 0, 0);
      check("R7 disabled suppresses doorbell", n_door, 0);
      issue(0, 2000, 0, 'h200, 0, 13, 2000, 8300, 1, 0, 0, 0);
      check("R7 clear raises no doorbell", n_door, 0);
      check("R8 clear gives no rescan", n_resc_dst, 0);
   endtask

   task automatic t_move();
      // id 77 -> byte +9, bit 5
      mem['h609] = 8'h21;
      issue(1, 77, 0, 'h700, 1, 13, 0, 0, 1, 'h600, 1, 77);
      check("R9 source bit cleared", int'(mem['h609]), 'h01);
      check("R10 source rescan", n_resc_src, 1);
      check("R10 source rescan precedes delivery", src_resc_before_chk, 1);
      check("R10 destination set", int'(mem['h709]), 'h20);
      check("R10 destination check id", last_chk_id, 77);
      check("R10 destination changed", last_changed, 1);
      issue(1, 77, 0, 'h700, 1, 13, 0, 0, 1, 'h600, 1, 77);
      check("R9 not pending single read", n_rd, 1);
      check("R9 no write", n_wr, 0);
      check("R9 no source rescan", n_resc_src, 0);
      check("R9 no delivery", n_chk, 0);
      mem['h609] = 8'h20;
      issue(1, 77, 0, 'h780, 1, 13, 0, 0, 1, 'h600, 1, 5);
      check("R10 no source rescan for non-best", n_resc_src, 0);
      check("R10 second destination set", int'(mem['h789]), 'h20);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      busy_bad = 0;
      t_reset();
      t_set_resident();
      t_unchanged();
      t_clear_best();
      t_clear_other();
      t_range();
      t_nonresident();
      t_move();
      check("R11 ready low during memory access", busy_bad, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2000000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule